// File: doc/BRIEF.md
# CPU exception entry controller

This block performs the processor-state rewrite that happens when a CPU core takes one of three events that no status bit can mask. The events are a reset, a stop request from the on-chip debug logic, and an unrecoverable exception. An unrecoverable exception arises when an ordinary exception request arrives while the core's exception-mask bit is already set. The block picks the winning event and produces the new status register and new program counter. It also captures the return status and return address into a debug context or an exception context. All of this happens in a single clock edge.

The surrounding pipeline gives the block the current status register, the current PC, the PC of the faulting instruction and the exception vector base. It reads back the registered results. A two-bit event code pulses for one cycle to say which event was taken. A separate pulse marks an exception request that this block does not handle because exceptions were unmasked, so the normal exception path can serve it. Pipeline flushing, instruction fetch and the debug instruction feed belong to other blocks.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On every rising edge with rst_n low, sr_o is set to SR_RST (default 32'h0040_0000), pc_o to RESET_PC (default 32'hA000_0000), all four context outputs to zero and evt_o to 2'b01. This happens whatever the state of dbg_stop_i and exc_req_i.
- R2: The status-register field positions are: R at bit 15, GM at bit 16, EM at bit 21, the mode field at bits 24:22, D at bit 26, DM at bit 27 and J at bit 28. Every other bit is carried from sr_i unchanged.
- R3: A debug stop (dbg_stop_i high) loads dbg_rsr_o with sr_i and dbg_rar_o with pc_i, and pc_o takes pc_i.
- R4: A debug stop writes sr_o as sr_i with mode = 3'b110, R = 0, J = 0, and D, DM, EM and GM all set to 1.
- R5: An unrecoverable exception is taken when exc_req_i is high and sr_i bit EM is 1. It loads exc_rsr_o with sr_i and exc_rar_o with fault_pc_i.
- R6: An unrecoverable exception writes sr_o as sr_i with mode = 3'b110, R = 0, J = 0, and EM and GM set, leaving D and DM unchanged. pc_o takes vbase_i + UNREC_OFS (default 0).
- R7: A debug stop takes priority over an unrecoverable exception. When both occur, only the debug context is written and the exception context keeps its value.
- R8: When exc_req_i is high with EM clear and no debug stop, no state changes: sr_o and pc_o take sr_i and pc_i, contexts hold, evt_o is 2'b00 and exc_pass_o is 1 for that cycle.
- R9: With no event and no request, sr_o and pc_o follow sr_i and pc_i one cycle later, the contexts hold, evt_o is 2'b00 and exc_pass_o is 0.
- R10: evt_o is a registered one-cycle code: 2'b01 for reset, 2'b10 for debug stop, 2'b11 for unrecoverable and 2'b00 otherwise. exc_pass_o is never high while evt_o is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset line of the core |
| dbg_stop_i | input | 1 | Stop request from the on-chip debug logic |
| exc_req_i | input | 1 | Ordinary exception request strobe |
| pc_i | input | XLEN | Current program counter |
| fault_pc_i | input | XLEN | PC of the instruction that raised the request |
| sr_i | input | XLEN | Current status register |
| vbase_i | input | XLEN | Exception vector base |
| sr_o | output | XLEN | Updated status register |
| pc_o | output | XLEN | New program counter |
| dbg_rsr_o | output | XLEN | Saved status for the debug context |
| dbg_rar_o | output | XLEN | Saved return address for the debug context |
| exc_rsr_o | output | XLEN | Saved status for the exception context |
| exc_rar_o | output | XLEN | Saved return address for the exception context |
| evt_o | output | 2 | One-cycle code of the event taken |
| exc_pass_o | output | 1 | Request not handled here (exceptions unmasked) |

## Verification
The bench applies a debug stop and a masked exception request in the same cycle. A design with the priority reversed would report 2'b11 and overwrite the exception context. It also raises a request with EM clear, both alone and together with a debug stop; a design that ignored the mask bit would vector to the base address or assert the pass pulse while taking the debug event. The status inputs carry a mode field already at 3'b001 or 3'b111, and R, J and D set. A rewrite that ORed in the mode, or that touched D on an unrecoverable exception, gives a wrong sr_o. Reset is asserted while both requests are high and the contexts are non-zero, which catches a design that lets an event beat reset or keeps stale contexts.

// File: rtl/exc_entry_pkg.sv
// Package: shared event encoding and status-register field positions for
// the exception entry controller. Assumes a status word of at least 29 bits.
package exc_entry_pkg;

    typedef enum logic [1:0] {
        EVT_NONE  = 2'b00,
        EVT_RST   = 2'b01,
        EVT_DBG   = 2'b10,
        EVT_UNREC = 2'b11
    } evt_e;

    localparam int SR_R    = 15;
    localparam int SR_GM   = 16;
    localparam int SR_EM   = 21;
    localparam int SR_M_LO = 22;
    localparam int SR_M_HI = 24;
    localparam int SR_D    = 26;
    localparam int SR_DM   = 27;
    localparam int SR_J    = 28;

    localparam logic [2:0] MODE_EXC = 3'b110;

endpackage

// File: rtl/exc_prio.sv
// Module: exc_prio
// Chooses the non-reset event for this cycle: debug stop first, then an
// unrecoverable exception (request while EM set). A request with EM clear
// is flagged for the normal exception path. Reset is resolved by the top.
module exc_prio
    import exc_entry_pkg::*;
(
    input  logic dbg_stop,
    input  logic exc_req,
    input  logic em_set,
    output evt_e sel,
    output logic pass
);

    // Fixed priority choice between the two maskless events.
    always_comb begin
        if (dbg_stop) begin
            sel = EVT_DBG;
        end else if (exc_req && em_set) begin
            sel = EVT_UNREC;
        end else begin
            sel = EVT_NONE;
        end
    end

    // Request left unhandled here because exceptions are unmasked.
    always_comb begin
        pass = exc_req && !em_set && !dbg_stop;
    end

endmodule

// File: rtl/exc_sr_xform.sv
// Module: exc_sr_xform
// Computes the rewritten status word for the selected event. Untouched
// fields pass through. Assumes XLEN covers the highest field (bit 28).
module exc_sr_xform
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] sr_cur,
    input  evt_e            sel,
    output logic [XLEN-1:0] sr_new
);

    // Apply the common entry writes, then the debug-only extras.
    always_comb begin
        sr_new = sr_cur;
        if (sel == EVT_DBG || sel == EVT_UNREC) begin
            sr_new[SR_M_HI:SR_M_LO] = MODE_EXC;
            sr_new[SR_R]            = 1'b0;
            sr_new[SR_J]            = 1'b0;
            sr_new[SR_EM]           = 1'b1;
            sr_new[SR_GM]           = 1'b1;
        end
        if (sel == EVT_DBG) begin
            sr_new[SR_D]  = 1'b1;
            sr_new[SR_DM] = 1'b1;
        end
    end

endmodule

// File: rtl/exc_ctx_reg.sv
// Module: exc_ctx_reg
// One saved context: a return-status and a return-address register that
// load together on request and clear during synchronous active-low reset.
module exc_ctx_reg #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] st_d,
    input  logic [XLEN-1:0] ad_d,
    output logic [XLEN-1:0] st_q,
    output logic [XLEN-1:0] ad_q
);

    // Capture the context on load, zero it in reset, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            ad_q <= '0;
        end else if (load) begin
            st_q <= st_d;
            ad_q <= ad_d;
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
// Module: exc_entry_ctrl (top)
// Applies reset, debug-stop and unrecoverable-exception entry in one edge:
// new status word, new PC, saved contexts and a one-cycle event code.
// Assumes synchronous active-low reset and XLEN >= 29.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] SR_RST    = 32'h0040_0000,
    parameter logic [XLEN-1:0] RESET_PC  = 32'hA000_0000,
    parameter logic [XLEN-1:0] UNREC_OFS = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbg_stop_i,
    input  logic            exc_req_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] fault_pc_i,
    input  logic [XLEN-1:0] sr_i,
    input  logic [XLEN-1:0] vbase_i,
    output logic [XLEN-1:0] sr_o,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] dbg_rsr_o,
    output logic [XLEN-1:0] dbg_rar_o,
    output logic [XLEN-1:0] exc_rsr_o,
    output logic [XLEN-1:0] exc_rar_o,
    output logic [1:0]      evt_o,
    output logic            exc_pass_o
);

    localparam int NCTX    = 2;
    localparam int CTX_DBG = 0;
    localparam int CTX_EXC = 1;

    evt_e            sel;
    logic            pass;
    logic [XLEN-1:0] sr_new;
    logic [XLEN-1:0] pc_new;
    logic [NCTX-1:0] ctx_ld;
    logic [XLEN-1:0] ctx_st_d [NCTX];
    logic [XLEN-1:0] ctx_ad_d [NCTX];
    logic [XLEN-1:0] ctx_st_q [NCTX];
    logic [XLEN-1:0] ctx_ad_q [NCTX];
    logic [XLEN-1:0] sr_q;
    logic [XLEN-1:0] pc_q;
    evt_e            evt_q;
    logic            pass_q;

    exc_prio u_prio (
        .dbg_stop (dbg_stop_i),
        .exc_req  (exc_req_i),
        .em_set   (sr_i[SR_EM]),
        .sel      (sel),
        .pass     (pass)
    );

    exc_sr_xform #(.XLEN(XLEN)) u_xform (
        .sr_cur (sr_i),
        .sel    (sel),
        .sr_new (sr_new)
    );

    // Next PC: vector for unrecoverable, otherwise the current PC.
    always_comb begin
        pc_new = (sel == EVT_UNREC) ? (vbase_i + UNREC_OFS) : pc_i;
    end

    // Context load strobes and data for each saved context.
    always_comb begin
        ctx_ld[CTX_DBG]   = (sel == EVT_DBG);
        ctx_st_d[CTX_DBG] = sr_i;
        ctx_ad_d[CTX_DBG] = pc_i;
        ctx_ld[CTX_EXC]   = (sel == EVT_UNREC);
        ctx_st_d[CTX_EXC] = sr_i;
        ctx_ad_d[CTX_EXC] = fault_pc_i;
    end

    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        exc_ctx_reg #(.XLEN(XLEN)) u_ctx (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (ctx_ld[g]),
            .st_d  (ctx_st_d[g]),
            .ad_d  (ctx_ad_d[g]),
            .st_q  (ctx_st_q[g]),
            .ad_q  (ctx_ad_q[g])
        );
    end

    // Register the new state and the event pulse; reset overrides all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= SR_RST;
            pc_q   <= RESET_PC;
            evt_q  <= EVT_RST;
            pass_q <= 1'b0;
        end else begin
            sr_q   <= sr_new;
            pc_q   <= pc_new;
            evt_q  <= sel;
            pass_q <= pass;
        end
    end

    assign sr_o       = sr_q;
    assign pc_o       = pc_q;
    assign evt_o      = evt_q;
    assign exc_pass_o = pass_q;
    assign dbg_rsr_o  = ctx_st_q[CTX_DBG];
    assign dbg_rar_o  = ctx_ad_q[CTX_DBG];
    assign exc_rsr_o  = ctx_st_q[CTX_EXC];
    assign exc_rar_o  = ctx_ad_q[CTX_EXC];

endmodule

// File: rtl/exc_entry_chk.sv
// Module: exc_entry_chk
// Property checker for exc_entry_ctrl, attached by bind below. It observes
// ports only, one cycle apart.
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] SR_RST    = 32'h0040_0000,
    parameter logic [XLEN-1:0] RESET_PC  = 32'hA000_0000,
    parameter logic [XLEN-1:0] UNREC_OFS = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dbg_stop_i,
    input logic            exc_req_i,
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] fault_pc_i,
    input logic [XLEN-1:0] sr_i,
    input logic [XLEN-1:0] vbase_i,
    input logic [XLEN-1:0] sr_o,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] dbg_rsr_o,
    input logic [XLEN-1:0] dbg_rar_o,
    input logic [XLEN-1:0] exc_rsr_o,
    input logic [XLEN-1:0] exc_rar_o,
    input logic [1:0]      evt_o,
    input logic            exc_pass_o
);

    logic past_valid;

    // Marks that at least one edge has passed, so $past is meaningful.
    always_ff @(posedge clk) begin
        past_valid <= 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && !$past(rst_n)) |->
        (evt_o == 2'b01 && pc_o == RESET_PC && sr_o == SR_RST &&
         dbg_rsr_o == '0 && exc_rar_o == '0));

    // R3
    dbg_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n && dbg_stop_i)) |->
        (evt_o == 2'b10 && dbg_rsr_o == $past(sr_i) &&
         dbg_rar_o == $past(pc_i) && pc_o == $past(pc_i)));

    // R4
    dbg_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n && dbg_stop_i)) |->
        (sr_o[SR_M_HI:SR_M_LO] == MODE_EXC && !sr_o[SR_R] && !sr_o[SR_J] &&
         sr_o[SR_D] && sr_o[SR_DM] && sr_o[SR_EM] && sr_o[SR_GM]));

    // R5
    unrec_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n && !dbg_stop_i && exc_req_i && sr_i[SR_EM])) |->
        (evt_o == 2'b11 && exc_rsr_o == $past(sr_i) &&
         exc_rar_o == $past(fault_pc_i)));

    // R6
    unrec_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n && !dbg_stop_i && exc_req_i && sr_i[SR_EM])) |->
        (pc_o == $past(vbase_i) + UNREC_OFS &&
         sr_o[SR_M_HI:SR_M_LO] == MODE_EXC && sr_o[SR_D] == $past(sr_i[SR_D])));

    // R7
    dbg_over_unrec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n) && $past(rst_n, 2) && $past(dbg_stop_i)) |->
        ($stable(exc_rsr_o) && $stable(exc_rar_o)));

    // R8
    pass_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n) && $past(rst_n, 2) &&
         $past(!dbg_stop_i && exc_req_i && !sr_i[SR_EM])) |->
        (exc_pass_o && evt_o == 2'b00 && sr_o == $past(sr_i) &&
         $stable(dbg_rsr_o) && $stable(exc_rsr_o)));

    // R10
    pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o != 2'b00) |-> !exc_pass_o);

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .XLEN(XLEN), .SR_RST(SR_RST), .RESET_PC(RESET_PC), .UNREC_OFS(UNREC_OFS)
) u_chk (.*);

// File: tb/exc_entry_ctrl_test.sv
// Bench: a vector table walked by one loop, then directed reset and
// corner-case tests. Inputs change on the falling edge, outputs are read
// on the next falling edge.
module exc_entry_ctrl_test;

    localparam int W = 32;

    typedef struct packed {
        logic         dbg;
        logic         exc;
        logic [W-1:0] sr;
        logic [W-1:0] pc;
        logic [W-1:0] fpc;
        logic [W-1:0] vb;
        logic [1:0]   e_evt;
        logic [W-1:0] e_sr;
        logic [W-1:0] e_pc;
        logic         e_pass;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R9 idle
        '{1'b0, 1'b0, 32'h0000_0000, 32'h0000_0100, 32'h0, 32'h8000_0000,
          2'b00, 32'h0000_0000, 32'h0000_0100, 1'b0},
        // R8 request with EM clear
        '{1'b0, 1'b1, 32'h0001_0000, 32'h0000_0200, 32'h0000_01FC, 32'h8000_0000,
          2'b00, 32'h0001_0000, 32'h0000_0200, 1'b1},
        // R5/R6 unrecoverable, R and J set
        '{1'b0, 1'b1, 32'h1020_8003, 32'h0000_0300, 32'h0000_0ABC, 32'h8000_4000,
          2'b11, 32'h01A1_0003, 32'h8000_4000, 1'b0},
        // R3/R4 debug stop, R and J set
        '{1'b1, 1'b0, 32'h1000_80F0, 32'h0000_3000, 32'h0000_0010, 32'h8000_4000,
          2'b10, 32'h0DA1_00F0, 32'h0000_3000, 1'b0},
        // R7 debug and masked request together, mode was 001
        '{1'b1, 1'b1, 32'h0060_0000, 32'h0000_4000, 32'h0000_5555, 32'h8000_4000,
          2'b10, 32'h0DA1_0000, 32'h0000_4000, 1'b0},
        // R6 unrecoverable, mode was 111 and D set (D kept)
        '{1'b0, 1'b1, 32'h05E0_0000, 32'h0000_0600, 32'h0000_0700, 32'h0000_0200,
          2'b11, 32'h05A1_0000, 32'h0000_0200, 1'b0},
        // R7 debug with unmasked request: no pass pulse
        '{1'b1, 1'b1, 32'h0000_0000, 32'h0000_0044, 32'h0000_0048, 32'h0000_0200,
          2'b10, 32'h0DA1_0000, 32'h0000_0044, 1'b0},
        // R10 back to idle: pulse ends
        '{1'b0, 1'b0, 32'h0000_1234, 32'h0000_0800, 32'h0, 32'h0000_0200,
          2'b00, 32'h0000_1234, 32'h0000_0800, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dbg_stop_i = 1'b0;
    logic         exc_req_i = 1'b0;
    logic [W-1:0] pc_i = '0;
    logic [W-1:0] fault_pc_i = '0;
    logic [W-1:0] sr_i = '0;
    logic [W-1:0] vbase_i = '0;
    logic [W-1:0] sr_o, pc_o, dbg_rsr_o, dbg_rar_o, exc_rsr_o, exc_rar_o;
    logic [1:0]   evt_o;
    logic         exc_pass_o;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    logic [W-1:0] m_drsr, m_drar, m_ersr, m_erar;

    always #5 clk = ~clk;

    exc_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dbg_stop_i(dbg_stop_i), .exc_req_i(exc_req_i),
        .pc_i(pc_i), .fault_pc_i(fault_pc_i), .sr_i(sr_i), .vbase_i(vbase_i),
        .sr_o(sr_o), .pc_o(pc_o), .dbg_rsr_o(dbg_rsr_o), .dbg_rar_o(dbg_rar_o),
        .exc_rsr_o(exc_rsr_o), .exc_rar_o(exc_rar_o), .evt_o(evt_o),
        .exc_pass_o(exc_pass_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_ctx(input string req);
        chk(req, "dbg_rsr", dbg_rsr_o, m_drsr);
        chk(req, "dbg_rar", dbg_rar_o, m_drar);
        chk(req, "exc_rsr", exc_rsr_o, m_ersr);
        chk(req, "exc_rar", exc_rar_o, m_erar);
    endtask

    task automatic chk_reset(input string req);
        chk(req, "evt", {30'd0, evt_o}, 32'd1);
        chk(req, "sr", sr_o, 32'h0040_0000);
        chk(req, "pc", pc_o, 32'hA000_0000);
        chk(req, "pass", {31'd0, exc_pass_o}, 32'd0);
        m_drsr = '0; m_drar = '0; m_ersr = '0; m_erar = '0;
        chk_ctx(req);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        // R1 reset state with requests idle
        repeat (3) @(negedge clk);
        chk_reset("R1");
        rst_n = 1'b1;

        // Table walk covering R2..R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            dbg_stop_i = VECS[i].dbg;
            exc_req_i  = VECS[i].exc;
            sr_i       = VECS[i].sr;
            pc_i       = VECS[i].pc;
            fault_pc_i = VECS[i].fpc;
            vbase_i    = VECS[i].vb;
            if (VECS[i].e_evt == 2'b10) begin
                m_drsr = VECS[i].sr;
                m_drar = VECS[i].pc;
            end else if (VECS[i].e_evt == 2'b11) begin
                m_ersr = VECS[i].sr;
                m_erar = VECS[i].fpc;
            end
            @(negedge clk);
            chk("R10", "evt", {30'd0, evt_o}, {30'd0, VECS[i].e_evt});
            chk("R2/R4/R6", "sr", sr_o, VECS[i].e_sr);
            chk("R3/R6/R9", "pc", pc_o, VECS[i].e_pc);
            chk("R8", "pass", {31'd0, exc_pass_o}, {31'd0, VECS[i].e_pass});
            chk_ctx("R7");
        end

        // R1 reset beats debug stop and a masked request; contexts are non-zero now
        @(negedge clk);
        dbg_stop_i = 1'b1;
        exc_req_i  = 1'b1;
        sr_i       = 32'h0020_0000;
        rst_n      = 1'b0;
        @(negedge clk);
        chk_reset("R1");

        // R10 release with requests still high: debug taken next edge
        rst_n = 1'b1;
        pc_i  = 32'h0000_0900;
        m_drsr = 32'h0020_0000;
        m_drar = 32'h0000_0900;
        @(negedge clk);
        chk("R10", "evt", {30'd0, evt_o}, 32'd2);
        chk_ctx("R3");

        // R8 unmasked request leaves contexts and state alone
        dbg_stop_i = 1'b0;
        sr_i       = 32'h0000_0005;
        pc_i       = 32'h0000_0A00;
        @(negedge clk);
        chk("R8", "pass", {31'd0, exc_pass_o}, 32'd1);
        chk("R8", "sr", sr_o, 32'h0000_0005);
        chk("R8", "pc", pc_o, 32'h0000_0A00);
        chk_ctx("R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule